// File: doc/BRIEF.md
# Operand-Select ALU with Compare Flag

This block is the arithmetic and logic stage of a small frame-processing sequencer. A 3-bit select code picks the first operand from a fixed set of datapath sources: the instruction immediate, either half of working register 1, working registers 2 and 3, either half of the status word, or the frame counter. The second operand arrives on its own port. A 4-bit control code chooses one of twelve operations. These are addition, subtraction in both orders, bitwise logic, inversion, three unsigned compares and a long add.

The block drives a 16-bit result, a compare flag and a 32-bit long result. The long add places the upper half of working register 1 above the selected operand and adds the second operand to the 32-bit value. The block has no storage. Every output is a function of the present inputs and settles within the cycle in which they are applied. Instruction decode, register write-back and branching on the flag belong to the surrounding sequencer.

Top module: `aluTop`

## Requirements
- R1: The operand-1 select code maps as follows. 0 gives immData. 1 gives wreg1[15:0]. 2 gives wreg2. 3 gives wreg3. 4 gives statusWord[31:16]. 5 gives statusWord[15:0]. 6 gives frameCount. 7 gives wreg1[31:16].
- R2: Control code 0 and the unused codes 12 to 15 drive result equal to operandB and flag equal to 0.
- R3: Control code 1 drives result = operand1 + operandB, modulo 2^16.
- R4: Control code 5 drives bitwise OR of the two operands. Code 6 drives bitwise AND. Code 7 drives bitwise XOR. Code 8 drives the bitwise inverse of operandB.
- R5: Control codes 2, 3 and 4 set flag when operand1 is equal to, greater than, or greater than or equal to operandB, comparing unsigned. For these codes result equals operandB.
- R6: For every control code other than 2, 3 and 4, flag is 0.
- R7: Control code 9 drives longResult = {wreg1[31:16], operand1} + operandB, modulo 2^32. result carries longResult[15:0].
- R8: Control code 10 drives result = operand1 - operandB. Code 11 drives result = operandB - operand1. Both wrap modulo 2^16.
- R9: For every control code other than 9, longResult equals result zero-extended to 32 bits.
- R10: The block has no state. A change on any input reaches the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| immData | input | 16 | Instruction immediate, operand-1 source 0 |
| wreg1 | input | 32 | Working register 1. The halves are sources 1 and 7, and the upper half is used by the long add |
| wreg2 | input | 16 | Working register 2, source 2 |
| wreg3 | input | 16 | Working register 3, source 3 |
| statusWord | input | 32 | Status word. The upper half is source 4 and the lower half is source 5 |
| frameCount | input | 16 | Frame counter, source 6 |
| opSel | input | 3 | Operand-1 select code |
| aluCtrl | input | 4 | Operation code |
| operandB | input | 16 | Second operand |
| result | output | 16 | 16-bit result |
| flag | output | 1 | Compare outcome |
| longResult | output | 32 | 32-bit result of the long add, otherwise result zero-extended |

## Verification
Every output of this block is due in the same cycle its inputs change, so the expected latency is zero clock edges. The bench applies each stimulus just after a rising edge and samples the result at the following falling edge, half a period later, with no register in between. One scenario changes the inputs between two edges and samples before any edge arrives. This shows that no result waits on the clock.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [2:0] {
    SRC_IMM    = 3'd0,
    SRC_W1LO   = 3'd1,
    SRC_W2     = 3'd2,
    SRC_W3     = 3'd3,
    SRC_STATHI = 3'd4,
    SRC_STATLO = 3'd5,
    SRC_FCNT   = 3'd6,
    SRC_W1HI   = 3'd7
  } srcSelE;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_EQ    = 4'd2,
    OP_GT    = 4'd3,
    OP_GE    = 4'd4,
    OP_OR    = 4'd5,
    OP_AND   = 4'd6,
    OP_XOR   = 4'd7,
    OP_INV   = 4'd8,
    OP_LADD  = 4'd9,
    OP_SUBAB = 4'd10,
    OP_SUBBA = 4'd11
  } aluOpE;

  // Strobes from the decoder to the datapath; at most one is set.
  // None set means pass operandB through.
  typedef struct packed {
    logic doAdd;
    logic doSubAB;
    logic doSubBA;
    logic doOr;
    logic doAnd;
    logic doXor;
    logic doInv;
    logic doLong;
    logic cmpEq;
    logic cmpGt;
    logic cmpGe;
  } aluStrobeT;

endpackage

// File: rtl/aluOperandSel.sv
module aluOperandSel #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic [DATA_W-1:0]   immData,
  input  logic [2*DATA_W-1:0] wreg1,
  input  logic [DATA_W-1:0]   wreg2,
  input  logic [DATA_W-1:0]   wreg3,
  input  logic [2*DATA_W-1:0] statusWord,
  input  logic [DATA_W-1:0]   frameCount,
  input  logic [SEL_W-1:0]    opSel,
  output logic [DATA_W-1:0]   operandA
);
  localparam int NUM_SRC = 1 << SEL_W;

  logic [DATA_W-1:0] srcBus [NUM_SRC];

  // Source positions follow the select code; spare slots read zero.
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) srcBus[i] = '0;
    srcBus[aluPkg::SRC_IMM]    = immData;
    srcBus[aluPkg::SRC_W1LO]   = wreg1[DATA_W-1:0];
    srcBus[aluPkg::SRC_W2]     = wreg2;
    srcBus[aluPkg::SRC_W3]     = wreg3;
    srcBus[aluPkg::SRC_STATHI] = statusWord[2*DATA_W-1:DATA_W];
    srcBus[aluPkg::SRC_STATLO] = statusWord[DATA_W-1:0];
    srcBus[aluPkg::SRC_FCNT]   = frameCount;
    srcBus[aluPkg::SRC_W1HI]   = wreg1[2*DATA_W-1:DATA_W];
  end

  assign operandA = srcBus[opSel];

endmodule

// File: rtl/aluDecode.sv
module aluDecode #(
  parameter int CTRL_W = 4
) (
  input  logic [CTRL_W-1:0] aluCtrl,
  output aluPkg::aluStrobeT strobe
);
  import aluPkg::*;

  always_comb begin
    strobe = '0;
    case (aluCtrl)
      OP_ADD:   strobe.doAdd   = 1'b1;
      OP_EQ:    strobe.cmpEq   = 1'b1;
      OP_GT:    strobe.cmpGt   = 1'b1;
      OP_GE:    strobe.cmpGe   = 1'b1;
      OP_OR:    strobe.doOr    = 1'b1;
      OP_AND:   strobe.doAnd   = 1'b1;
      OP_XOR:   strobe.doXor   = 1'b1;
      OP_INV:   strobe.doInv   = 1'b1;
      OP_LADD:  strobe.doLong  = 1'b1;
      OP_SUBAB: strobe.doSubAB = 1'b1;
      OP_SUBBA: strobe.doSubBA = 1'b1;
      default:  strobe = '0;   // no-op and spare codes: pass operandB
    endcase
  end

endmodule

// File: rtl/aluCore.sv
module aluCore #(
  parameter int DATA_W = 16
) (
  input  aluPkg::aluStrobeT     strobe,
  input  logic [DATA_W-1:0]     operandA,
  input  logic [DATA_W-1:0]     operandB,
  input  logic [DATA_W-1:0]     longHigh,
  output logic [DATA_W-1:0]     result,
  output logic                  flag,
  output logic [2*DATA_W-1:0]   longResult
);
  localparam int WIDE_W = 2 * DATA_W;

  logic [DATA_W-1:0] sumAB;
  logic [DATA_W-1:0] diffAB;
  logic [DATA_W-1:0] diffBA;
  logic [WIDE_W-1:0] longSum;
  logic              isEq;
  logic              isGt;

  assign sumAB   = operandA + operandB;
  assign diffAB  = operandA - operandB;
  assign diffBA  = operandB - operandA;
  assign longSum = {longHigh, operandA} + {{DATA_W{1'b0}}, operandB};
  assign isEq    = (operandA == operandB);
  assign isGt    = (operandA > operandB);

  always_comb begin
    result = operandB;
    if (strobe.doAdd)   result = sumAB;
    if (strobe.doSubAB) result = diffAB;
    if (strobe.doSubBA) result = diffBA;
    if (strobe.doOr)    result = operandA | operandB;
    if (strobe.doAnd)   result = operandA & operandB;
    if (strobe.doXor)   result = operandA ^ operandB;
    if (strobe.doInv)   result = ~operandB;
    if (strobe.doLong)  result = longSum[DATA_W-1:0];
  end

  assign flag = (strobe.cmpEq & isEq)
              | (strobe.cmpGt & isGt)
              | (strobe.cmpGe & (isGt | isEq));

  assign longResult = strobe.doLong ? longSum : {{DATA_W{1'b0}}, result};

endmodule

// File: rtl/aluTop.sv
module aluTop #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3,
  parameter int CTRL_W = 4
) (
  input  logic [DATA_W-1:0]   immData,
  input  logic [2*DATA_W-1:0] wreg1,
  input  logic [DATA_W-1:0]   wreg2,
  input  logic [DATA_W-1:0]   wreg3,
  input  logic [2*DATA_W-1:0] statusWord,
  input  logic [DATA_W-1:0]   frameCount,
  input  logic [SEL_W-1:0]    opSel,
  input  logic [CTRL_W-1:0]   aluCtrl,
  input  logic [DATA_W-1:0]   operandB,
  output logic [DATA_W-1:0]   result,
  output logic                flag,
  output logic [2*DATA_W-1:0] longResult
);
  logic [DATA_W-1:0] operandA;
  aluPkg::aluStrobeT strobe;

  aluOperandSel #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_sel (
    .immData    (immData),
    .wreg1      (wreg1),
    .wreg2      (wreg2),
    .wreg3      (wreg3),
    .statusWord (statusWord),
    .frameCount (frameCount),
    .opSel      (opSel),
    .operandA   (operandA)
  );

  aluDecode #(.CTRL_W(CTRL_W)) u_dec (
    .aluCtrl (aluCtrl),
    .strobe  (strobe)
  );

  aluCore #(.DATA_W(DATA_W)) u_core (
    .strobe     (strobe),
    .operandA   (operandA),
    .operandB   (operandB),
    .longHigh   (wreg1[2*DATA_W-1:DATA_W]),
    .result     (result),
    .flag       (flag),
    .longResult (longResult)
  );

endmodule

// File: rtl/aluTopChk.sv
module aluTopChk #(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 4
) (
  input logic [CTRL_W-1:0]   aluCtrl,
  input logic [DATA_W-1:0]   operandB,
  input logic [DATA_W-1:0]   result,
  input logic                flag,
  input logic [2*DATA_W-1:0] longResult
);
  logic isCmp;
  logic isPass;
  assign isCmp  = (aluCtrl == 4'd2) || (aluCtrl == 4'd3) || (aluCtrl == 4'd4);
  assign isPass = (aluCtrl == 4'd0) || (aluCtrl >= 4'd12);

  always_comb begin
    if (isPass) AST_PASS_SPARE: assert (result == operandB && !flag);        // R2
    if (isCmp)  AST_CMP_KEEPS_B: assert (result == operandB);                // R5
    if (!isCmp) AST_FLAG_ONLY_CMP: assert (!flag);                           // R6
    AST_LONG_LOW_MATCH: assert (longResult[DATA_W-1:0] == result);           // R7
    if (aluCtrl != 4'd9)
      AST_LONG_ZERO_EXT: assert (longResult[2*DATA_W-1:DATA_W] == '0);      // R9
  end

endmodule

bind aluTop aluTopChk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
  .aluCtrl    (aluCtrl),
  .operandB   (operandB),
  .result     (result),
  .flag       (flag),
  .longResult (longResult)
);

// File: tb/aluTop_tb.sv
module aluTop_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] immData = '0;
  logic [31:0] wreg1 = '0;
  logic [15:0] wreg2 = '0;
  logic [15:0] wreg3 = '0;
  logic [31:0] statusWord = '0;
  logic [15:0] frameCount = '0;
  logic [2:0]  opSel = '0;
  logic [3:0]  aluCtrl = '0;
  logic [15:0] operandB = '0;
  logic [15:0] result;
  logic        flag;
  logic [31:0] longResult;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  aluTop u_dut (
    .immData(immData), .wreg1(wreg1), .wreg2(wreg2), .wreg3(wreg3),
    .statusWord(statusWord), .frameCount(frameCount), .opSel(opSel),
    .aluCtrl(aluCtrl), .operandB(operandB), .result(result),
    .flag(flag), .longResult(longResult)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply after a rising edge; outputs are combinational, so sample at the next falling edge.
  task automatic applyOp(input logic [2:0] sel, input logic [3:0] op,
                         input logic [15:0] a, input logic [15:0] b);
    @(posedge clk);
    opSel = sel; aluCtrl = op; immData = a; operandB = b;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R2 reset result", {16'h0, result}, 32'h0);
    chk("R2 reset flag", {31'h0, flag}, 32'h0);
    chk("R9 reset long", longResult, 32'h0);
  endtask

  task automatic testSelect();
    logic [15:0] expA [8];
    wreg1 = 32'hA5A5_2222; wreg2 = 16'h3333; wreg3 = 16'h4444;
    statusWord = 32'h5555_6666; frameCount = 16'h7777;
    expA = '{16'h1111, 16'h2222, 16'h3333, 16'h4444,
             16'h5555, 16'h6666, 16'h7777, 16'hA5A5};
    for (int s = 0; s < 8; s++) begin
      applyOp(3'(s), 4'd5, 16'h1111, 16'h0000);   // OR with zero exposes operand 1
      chk($sformatf("R1 select %0d", s), {16'h0, result}, {16'h0, expA[s]});
    end
  endtask

  task automatic testAdd();
    applyOp(3'd0, 4'd1, 16'h1234, 16'h1111);
    chk("R3 add", {16'h0, result}, 32'h2345);
    chk("R6 add flag", {31'h0, flag}, 32'h0);
    chk("R9 add long", longResult, 32'h0000_2345);
    applyOp(3'd0, 4'd1, 16'hFFFF, 16'h0002);
    chk("R3 add wrap", {16'h0, result}, 32'h0001);
    chk("R9 add wrap long", longResult, 32'h0000_0001);
  endtask

  task automatic testLogic();
    applyOp(3'd0, 4'd5, 16'hF0F0, 16'hFF00);
    chk("R4 or", {16'h0, result}, 32'hFFF0);
    applyOp(3'd0, 4'd6, 16'hF0F0, 16'hFF00);
    chk("R4 and", {16'h0, result}, 32'hF000);
    applyOp(3'd0, 4'd7, 16'hF0F0, 16'hFF00);
    chk("R4 xor", {16'h0, result}, 32'h0FF0);
    chk("R6 xor flag", {31'h0, flag}, 32'h0);
    applyOp(3'd0, 4'd8, 16'hF0F0, 16'hFF00);
    chk("R4 inv", {16'h0, result}, 32'h00FF);
  endtask

  task automatic testCompare();
    // unsigned: 8000 > 7FFF
    applyOp(3'd0, 4'd2, 16'h8000, 16'h7FFF); chk("R5 eq hi", {31'h0, flag}, 0);
    chk("R5 cmp result", {16'h0, result}, 32'h7FFF);
    applyOp(3'd0, 4'd3, 16'h8000, 16'h7FFF); chk("R5 gt hi", {31'h0, flag}, 1);
    applyOp(3'd0, 4'd4, 16'h8000, 16'h7FFF); chk("R5 ge hi", {31'h0, flag}, 1);
    applyOp(3'd0, 4'd2, 16'h1234, 16'h1234); chk("R5 eq same", {31'h0, flag}, 1);
    applyOp(3'd0, 4'd3, 16'h1234, 16'h1234); chk("R5 gt same", {31'h0, flag}, 0);
    applyOp(3'd0, 4'd4, 16'h1234, 16'h1234); chk("R5 ge same", {31'h0, flag}, 1);
    applyOp(3'd0, 4'd2, 16'h0001, 16'hFFFF); chk("R5 eq lo", {31'h0, flag}, 0);
    applyOp(3'd0, 4'd3, 16'h0001, 16'hFFFF); chk("R5 gt lo", {31'h0, flag}, 0);
    applyOp(3'd0, 4'd4, 16'h0001, 16'hFFFF); chk("R5 ge lo", {31'h0, flag}, 0);
    chk("R9 cmp long", longResult, 32'h0000_FFFF);
  endtask

  task automatic testLongAdd();
    wreg1 = 32'h0001_0000;
    applyOp(3'd0, 4'd9, 16'hFFFF, 16'h0002);
    chk("R7 long carry", longResult, 32'h0002_0001);
    chk("R7 long low", {16'h0, result}, 32'h0001);
    chk("R6 long flag", {31'h0, flag}, 32'h0);
    wreg1 = 32'hFFFF_0000;
    applyOp(3'd0, 4'd9, 16'hFFFF, 16'h0001);
    chk("R7 long wrap", longResult, 32'h0000_0000);
  endtask

  task automatic testSubtract();
    applyOp(3'd0, 4'd10, 16'h0005, 16'h0007);
    chk("R8 a-b", {16'h0, result}, 32'hFFFE);
    chk("R9 sub long", longResult, 32'h0000_FFFE);
    applyOp(3'd0, 4'd11, 16'h0005, 16'h0007);
    chk("R8 b-a", {16'h0, result}, 32'h0002);
  endtask

  task automatic testPassCodes();
    logic [3:0] codes [5];
    codes = '{4'd0, 4'd12, 4'd13, 4'd14, 4'd15};
    for (int k = 0; k < 5; k++) begin
      applyOp(3'd0, codes[k], 16'h0001, 16'hBEEF);
      chk($sformatf("R2 code %0d result", codes[k]), {16'h0, result}, 32'hBEEF);
      chk($sformatf("R2 code %0d flag", codes[k]), {31'h0, flag}, 32'h0);
      chk($sformatf("R9 code %0d long", codes[k]), longResult, 32'h0000_BEEF);
    end
  endtask

  task automatic testNoClock();
    @(posedge clk);
    #3;
    opSel = 3'd0; aluCtrl = 4'd1; immData = 16'h0100; operandB = 16'h0023;
    #2;
    chk("R10 mid-cycle add", {16'h0, result}, 32'h0123);
    operandB = 16'h0024;
    #2;
    chk("R10 mid-cycle update", {16'h0, result}, 32'h0124);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    testReset();
    rstN = 1'b1;
    testSelect();
    testAdd();
    testLogic();
    testCompare();
    testLongAdd();
    testSubtract();
    testPassCodes();
    testNoClock();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule